// File: doc/BRIEF.md
# Presettable Saturating Error Counter Bank

This block keeps four running tallies of line-error events for a T1 receive monitor: a 16-bit bipolar-violation tally and three 8-bit tallies for CRC word errors, out-of-frame events and framing-bit errors. The host can load a start value into any tally so that it acts as a threshold. From that value the tally counts up by one per qualifying event and stops at all ones instead of wrapping. Any event that arrives once a tally is full latches a sticky status bit. If the matching mask bit is set, that status bit pulls an active-low interrupt.

The event detectors sit outside this block and deliver single-cycle pulses. Alongside the pulses, the block takes a loss-of-sync level, the framing mode (superframe or extended superframe), a control bit that picks which framing patterns feed the frame-error tally, and a clear-on-read control. The host reaches the tallies through byte-wide read and write strobes. The wide tally is loaded through a staging byte, so its two halves change together.

Top module: `err_cnt_bank`

## Requirements
- R1: After reset all four tallies read 0, `sat_stat` is 0 and `irq_n` is 1.
- R2: A write to address 2 (CRC), 3 (out-of-frame) or 4 (frame-error) loads that 8-bit tally. A read strobe returns the addressed value on `rdata` one clock later.
- R3: A write to address 0 only stages the low byte and leaves the 16-bit violation tally unchanged. A write to address 1 loads the tally with {written byte, staged byte}. Reads of addresses 0 and 1 return its low and high bytes.
- R4: Each qualifying event adds one to its tally. A tally at 65535 (violation) or 255 (others) holds that value and never wraps.
- R5: An event on a full tally sets its `sat_stat` bit (bit 0 violation, 1 CRC, 2 out-of-frame, 3 frame-error). `irq_n` goes low one clock later only if the matching `irq_mask` bit is 1.
- R6: A `stat_rd` pulse clears all `sat_stat` bits, and `irq_n` returns high.
- R7: While `sync_lost` is 1 the violation tally keeps counting, and the other three ignore their events.
- R8: While `ext_mode` is 0 (superframe) the CRC tally is held at 0, and both events and writes to it are ignored.
- R9: The frame-error tally counts `ev_fpat` pulses. In superframe mode with `fe_both` = 1 it also counts `ev_spat` pulses. `ev_spat` is ignored in extended mode or when `fe_both` = 0.
- R10: With `auto_clr` = 1, any read strobe returns the pre-clear value and clears all four tallies. With `auto_clr` = 0, reads leave the tallies unchanged.
- R11: An event arriving in the same cycle as a clearing read leaves its tally at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_viol | input | 1 | Bipolar-violation event pulse |
| ev_crc | input | 1 | CRC word-error event pulse |
| ev_oof | input | 1 | Out-of-frame event pulse |
| ev_fpat | input | 1 | Terminal / frame-pattern bit-error pulse |
| ev_spat | input | 1 | Signaling-pattern bit-error pulse |
| sync_lost | input | 1 | Loss-of-sync level |
| ext_mode | input | 1 | 1 = extended superframe, 0 = superframe |
| fe_both | input | 1 | Superframe: also count signaling-pattern errors |
| auto_clr | input | 1 | Reads clear all tallies |
| irq_mask | input | 4 | Interrupt enable per tally |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| stat_rd | input | 1 | Status read: clears sticky bits |
| rdata | output | 8 | Registered read data |
| sat_stat | output | 4 | Sticky post-saturation status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to reach is an event landing on a full 16-bit tally. Counting up from zero would take 65535 pulses, so the bench first loads 0xFFFE through the staged two-byte write and then sends two pulses: the first reaches saturation and the second must raise status. Another hard case is an event in the very cycle of a clearing read. The bench drives the read strobe and the event pulse on the same falling edge, and after that checks that the returned byte is the old value and that the tally then reads 1.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int N_CNT = 4;
  localparam int N_SML = 3;
  localparam logic [2:0] A_VLO = 3'd0;
  localparam logic [2:0] A_VHI = 3'd1;
  localparam logic [2:0] A_CRC = 3'd2;
  localparam logic [2:0] A_OOF = 3'd3;
  localparam logic [2:0] A_FER = 3'd4;
  typedef enum logic [1:0] {IX_VIOL = 2'd0, IX_CRC = 2'd1, IX_OOF = 2'd2, IX_FER = 2'd3} cnt_idx_e;
endpackage

// File: rtl/ecb_cnt.sv
module ecb_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_zero,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         sat_hit
);
  localparam logic [W-1:0] FULL = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic full;
  assign full    = (cnt == FULL);
  assign sat_hit = inc & full & ~ld & ~clr & ~hold_zero;

  always_ff @(posedge clk) begin
    if (rst || hold_zero) begin
      cnt <= '0;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (clr) begin
      cnt <= inc ? ONE : '0;
    end else if (inc && !full) begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/ecb_irq.sv
module ecb_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] mask,
  input  logic         clr,
  output logic [N-1:0] stat,
  output logic         irq_n
);
  logic [N-1:0] stat_nxt;
  assign stat_nxt = (stat & {N{~clr}}) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat  <= '0;
      irq_n <= 1'b1;
    end else begin
      stat  <= stat_nxt;
      irq_n <= ~|(stat_nxt & mask);
    end
  end
endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank
  import ecb_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_viol,
  input  logic          ev_crc,
  input  logic          ev_oof,
  input  logic          ev_fpat,
  input  logic          ev_spat,
  input  logic          sync_lost,
  input  logic          ext_mode,
  input  logic          fe_both,
  input  logic          auto_clr,
  input  logic [N_CNT-1:0] irq_mask,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          stat_rd,
  output logic [DW-1:0] rdata,
  output logic [N_CNT-1:0] sat_stat,
  output logic          irq_n
);
  localparam int VW = 2 * DW;

  logic          clr_all;
  logic [DW-1:0] viol_stage;
  logic [VW-1:0] viol_cnt;
  logic          viol_hit;
  logic [DW-1:0] sm_cnt [N_SML];
  logic [N_SML-1:0] sm_inc, sm_ld, sm_hold, sm_hit;
  logic          fe_ev;
  logic [N_CNT-1:0] hit;

  assign clr_all = auto_clr & rd_en;
  // frame-error source selection depends on framing mode
  assign fe_ev = ev_fpat | (~ext_mode & fe_both & ev_spat);

  always_comb begin
    sm_inc[0]  = ev_crc & ~sync_lost;
    sm_inc[1]  = ev_oof & ~sync_lost;
    sm_inc[2]  = fe_ev  & ~sync_lost;
    sm_hold    = {2'b00, ~ext_mode};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_stage <= '0;
    end else if (wr_en && addr == AW'(A_VLO)) begin
      viol_stage <= wdata;
    end
  end

  ecb_cnt #(.W(VW)) u_viol (
    .clk(clk), .rst(rst), .hold_zero(1'b0),
    .ld(wr_en && addr == AW'(A_VHI)), .ld_val({wdata, viol_stage}),
    .clr(clr_all), .inc(ev_viol), .cnt(viol_cnt), .sat_hit(viol_hit)
  );

  for (genvar i = 0; i < N_SML; i++) begin : g_sml
    assign sm_ld[i] = wr_en && (addr == AW'(A_CRC) + AW'(i));
    ecb_cnt #(.W(DW)) u_cnt (
      .clk(clk), .rst(rst), .hold_zero(sm_hold[i]),
      .ld(sm_ld[i]), .ld_val(wdata),
      .clr(clr_all), .inc(sm_inc[i]), .cnt(sm_cnt[i]), .sat_hit(sm_hit[i])
    );
  end

  assign hit = {sm_hit, viol_hit};

  ecb_irq #(.N(N_CNT)) u_irq (
    .clk(clk), .rst(rst), .hit(hit), .mask(irq_mask), .clr(stat_rd),
    .stat(sat_stat), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        AW'(A_VLO): rdata <= viol_cnt[DW-1:0];
        AW'(A_VHI): rdata <= viol_cnt[VW-1:DW];
        AW'(A_CRC): rdata <= sm_cnt[0];
        AW'(A_OOF): rdata <= sm_cnt[1];
        AW'(A_FER): rdata <= sm_cnt[2];
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ecb_checker.sv
module ecb_checker #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_n,
  input logic [3:0]      sat_stat,
  input logic [3:0]      irq_mask,
  input logic [3:0]      hit,
  input logic            stat_rd,
  input logic            ext_mode,
  input logic            sync_lost,
  input logic            wr_en,
  input logic            rd_en,
  input logic            auto_clr,
  input logic [AW-1:0]   addr,
  input logic            ev_viol,
  input logic            ev_oof,
  input logic [2*DW-1:0] viol_cnt,
  input logic [DW-1:0]   crc_cnt,
  input logic [DW-1:0]   oof_cnt
);
  p_stage_only_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(0) && !ev_viol && !(auto_clr && rd_en)) |=> $stable(viol_cnt));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (viol_cnt == {2*DW{1'b1}} && !wr_en && !(auto_clr && rd_en)) |=> viol_cnt == {2*DW{1'b1}});

  p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> |(sat_stat & $past(irq_mask)));

  p_stat_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && hit == 4'b0) |=> sat_stat == 4'b0);

  p_oof_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (sync_lost && !wr_en && !(auto_clr && rd_en)) |=> $stable(oof_cnt));

  p_crc_held_r8: assert property (@(posedge clk) disable iff (rst)
    !ext_mode |=> crc_cnt == '0);

  p_read_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (auto_clr && rd_en && !wr_en && !ev_oof) |=> oof_cnt == '0);
endmodule

bind err_cnt_bank ecb_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .irq_n(irq_n), .sat_stat(sat_stat), .irq_mask(irq_mask),
  .hit(hit), .stat_rd(stat_rd), .ext_mode(ext_mode), .sync_lost(sync_lost),
  .wr_en(wr_en), .rd_en(rd_en), .auto_clr(auto_clr), .addr(addr),
  .ev_viol(ev_viol), .ev_oof(ev_oof), .viol_cnt(viol_cnt),
  .crc_cnt(sm_cnt[0]), .oof_cnt(sm_cnt[1])
);

// File: tb/err_cnt_bank_bench.sv
module err_cnt_bank_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_viol = 0, ev_crc = 0, ev_oof = 0, ev_fpat = 0, ev_spat = 0;
  logic sync_lost = 0, ext_mode = 1, fe_both = 0, auto_clr = 0;
  logic [3:0] irq_mask = 4'b0000;
  logic wr_en = 0, rd_en = 0, stat_rd = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] sat_stat;
  logic irq_n;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  err_cnt_bank u_err_cnt_bank (
    .clk(clk), .rst(rst), .ev_viol(ev_viol), .ev_crc(ev_crc), .ev_oof(ev_oof),
    .ev_fpat(ev_fpat), .ev_spat(ev_spat), .sync_lost(sync_lost), .ext_mode(ext_mode),
    .fe_both(fe_both), .auto_clr(auto_clr), .irq_mask(irq_mask), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .stat_rd(stat_rd), .rdata(rdata),
    .sat_stat(sat_stat), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  // bits: {viol, crc, oof, fpat, spat}
  task automatic pulse(input logic [4:0] ev);
    @(negedge clk); {ev_viol, ev_crc, ev_oof, ev_fpat, ev_spat} = ev;
    @(negedge clk); {ev_viol, ev_crc, ev_oof, ev_fpat, ev_spat} = '0;
  endtask

  task automatic clr_stat();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq_n", irq_n, 1);
    chk("R1 sat_stat", sat_stat, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 tally", v, 0);
    end
  endtask

  task automatic t_preset();
    logic [7:0] v;
    wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33);
    rd(3'd2, v); chk("R2 crc", v, 8'h11);
    rd(3'd3, v); chk("R2 oof", v, 8'h22);
    rd(3'd4, v); chk("R2 fer", v, 8'h33);
    rd(3'd4, v); chk("R10 no-clear reread", v, 8'h33);
  endtask

  task automatic t_stage();
    logic [7:0] v;
    wr(3'd0, 8'hAB);
    rd(3'd0, v); chk("R3 lo before hi", v, 0);
    rd(3'd1, v); chk("R3 hi before hi", v, 0);
    wr(3'd1, 8'hCD);
    rd(3'd0, v); chk("R3 lo", v, 8'hAB);
    rd(3'd1, v); chk("R3 hi", v, 8'hCD);
  endtask

  task automatic t_sat_viol();
    logic [7:0] v;
    irq_mask = 4'b0001;
    wr(3'd3, 8'h05);
    for (int i = 0; i < 3; i++) pulse(5'b00100);
    rd(3'd3, v); chk("R4 oof count", v, 8'h08);
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
    pulse(5'b10000);
    chk("R5 no stat at reach", sat_stat, 0);
    chk("R5 irq idle at reach", irq_n, 1);
    pulse(5'b10000);
    chk("R5 viol stat", sat_stat, 4'b0001);
    chk("R5 irq low", irq_n, 0);
    rd(3'd0, v); chk("R4 no wrap lo", v, 8'hFF);
    rd(3'd1, v); chk("R4 no wrap hi", v, 8'hFF);
    clr_stat();
    chk("R6 stat cleared", sat_stat, 0);
    chk("R6 irq released", irq_n, 1);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    irq_mask = 4'b0001;
    wr(3'd3, 8'hFF);
    pulse(5'b00100);
    chk("R5 oof stat", sat_stat, 4'b0100);
    chk("R5 masked irq", irq_n, 1);
    rd(3'd3, v); chk("R4 oof hold", v, 8'hFF);
    clr_stat();
    chk("R6 oof stat cleared", sat_stat, 0);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    sync_lost = 1;
    pulse(5'b10110);
    sync_lost = 0;
    rd(3'd0, v); chk("R7 viol counts", v, 1);
    rd(3'd3, v); chk("R7 oof frozen", v, 0);
    rd(3'd4, v); chk("R7 fer frozen", v, 0);
  endtask

  task automatic t_crc();
    logic [7:0] v;
    ext_mode = 0;
    wr(3'd2, 8'h40);
    pulse(5'b01000);
    rd(3'd2, v); chk("R8 crc held", v, 0);
    ext_mode = 1;
    wr(3'd2, 8'h40);
    pulse(5'b01000);
    rd(3'd2, v); chk("R8 crc counts ext", v, 8'h41);
  endtask

  task automatic t_fe();
    logic [7:0] v;
    ext_mode = 1; fe_both = 1;
    wr(3'd4, 8'h00);
    pulse(5'b00001);
    rd(3'd4, v); chk("R9 spat ignored ext", v, 0);
    pulse(5'b00010);
    rd(3'd4, v); chk("R9 fpat ext", v, 1);
    ext_mode = 0; fe_both = 0;
    pulse(5'b00001);
    rd(3'd4, v); chk("R9 spat ignored sf", v, 1);
    pulse(5'b00010);
    rd(3'd4, v); chk("R9 fpat sf", v, 2);
    fe_both = 1;
    pulse(5'b00001);
    rd(3'd4, v); chk("R9 spat both", v, 3);
    ext_mode = 1; fe_both = 0;
  endtask

  task automatic t_autoclr();
    logic [7:0] v;
    wr(3'd3, 8'h30); wr(3'd0, 8'h02); wr(3'd1, 8'h01); wr(3'd4, 8'h09);
    auto_clr = 1;
    rd(3'd3, v); chk("R10 pre-clear value", v, 8'h30);
    auto_clr = 0;
    rd(3'd3, v); chk("R10 oof cleared", v, 0);
    rd(3'd1, v); chk("R10 viol cleared", v, 0);
    rd(3'd4, v); chk("R10 fer cleared", v, 0);
    wr(3'd3, 8'h07);
    auto_clr = 1;
    @(negedge clk); rd_en = 1; addr = 3'd3; ev_oof = 1;
    @(negedge clk); rd_en = 0; ev_oof = 0; v = rdata;
    auto_clr = 0;
    chk("R11 returned old", v, 8'h07);
    rd(3'd3, v); chk("R11 event kept", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_preset();
    t_stage();
    t_sat_viol();
    t_mask();
    t_sync();
    t_crc();
    t_fe();
    t_autoclr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule